// File: doc/BRIEF.md
# Diagnostic Memory Window

This block gives an external host a way to read and write any 32-bit word of target memory through a small byte-wide register port. The port carries four 4-byte registers. Two of them hold addresses, one for reads and one for writes. The third holds a data word, and the fourth reports status. The host can build a target address one byte at a time. Writing any of the upper three bytes only stages bits. The access starts when the host writes the lowest byte of an address register.

For a store, the host first fills the data register and then programs the write address, ending with byte 0. For a fetch, the host programs the read address, ending with byte 0, waits for the busy flag to drop, and then reads the data register. Longer transfers are a series of such cycles, with the host stepping the address by 4. On the target side there is a single-word master port. It holds a request until it sees a grant, and read data returns later on a valid pulse.

The cycle sequencer has four states. ST_IDLE goes to ST_RD_REQ on a read trigger, or to ST_WR_REQ on a write trigger. ST_RD_REQ goes to ST_RD_WAIT on a grant. ST_RD_WAIT goes back to ST_IDLE on read-data-valid. ST_WR_REQ goes back to ST_IDLE on a grant.

Top module: `diag_window`

## Requirements
- R1: After reset, every register reads as zero, `mem_req` is low and the status byte is 0x00.
- R2: A host write to offsets 1–3 (read address) or 5–7 (write address) stores that byte into bits [8k+7:8k], where k is the offset's low two bits. The write causes no memory request, and the byte can be read back at the same offset.
- R3: When idle, a write to offset 0 stores address bits [7:0] and starts a read. On the next cycle `mem_req`=1 and `mem_we`=0. `mem_addr` equals the assembled read address with bits [1:0] forced to zero.
- R4: When idle, a write to offset 4 stores address bits [7:0] and starts a write. On the next cycle `mem_req`=1 and `mem_we`=1. `mem_wdata` holds the data register value from the moment of the trigger, and the address is aligned as in R3.
- R5: While `mem_req` is high and `mem_gnt` is low, the request stays asserted, and `mem_addr` and `mem_we` do not change.
- R6: During a read, the edge that samples `mem_rvalid` loads `mem_rdata` into the data register and clears busy. The data register is read little-endian at offsets 8–11, byte k at offset 8+k. A host write to these offsets replaces byte k.
- R7: A write cycle ends, and busy clears, at the edge where `mem_gnt` is sampled high.
- R8: A read of offset 12 returns a status byte. Bit 0 is busy, meaning a cycle is in flight. Bit 1 is overrun. All other bits read 0.
- R9: A write to offset 0 or 4 while busy stores the byte but starts no cycle, and it sets overrun. Overrun stays set until the host writes offset 12 with bit 1 = 1. A write with bit 1 = 0 leaves it set.
- R10: Writing the same value to one staging byte several times in a row has no side effect. No memory traffic results, the status does not change, and the stored bytes are unchanged.
- R11: Every host read or write strobe is answered by `host_ready` high on the following cycle. For a read, `host_rdata` is valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | HOST_AW | Host byte offset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid with host_ready |
| host_ready | output | 1 | Acknowledge, one cycle after a strobe |
| mem_req | output | 1 | Target access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | MEM_AW | Word-aligned target byte address |
| mem_wdata | output | MEM_DW | Target write word |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid pulse |
| mem_rdata | input | MEM_DW | Target read word |

## Verification
The hardest situation to reach is a second trigger landing while a cycle is still in flight. A fast memory finishes a cycle in a few clocks, so back-to-back host writes usually find the block idle. The bench switches its behavioural RAM into a slow mode that delays the read-data pulse by several cycles. It then issues a read trigger, a status read and two further triggers on consecutive cycles. This guarantees that both late triggers hit ST_RD_REQ or ST_RD_WAIT. Random traffic that alternates the two address-programming orders then covers the normal round trips.

// File: rtl/diag_window_pkg.sv
package diag_window_pkg;

    // Cycle sequencer states
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_REQ  = 2'd1,
        ST_RD_WAIT = 2'd2,
        ST_WR_REQ  = 2'd3
    } cyc_state_t;

    // Register selected by host_addr[3:2]
    typedef enum logic [1:0] {
        RSEL_RADDR = 2'd0,
        RSEL_WADDR = 2'd1,
        RSEL_DATA  = 2'd2,
        RSEL_STAT  = 2'd3
    } reg_sel_t;

    localparam int REG_LANES   = 4;  // byte lanes per host-visible register
    localparam int STAT_BUSY   = 0;
    localparam int STAT_OVR    = 1;

endpackage

// File: rtl/diag_byte_reg.sv
module diag_byte_reg #(
    parameter int NBYTES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [1:0]            lane,
    input  logic [7:0]            wdata,
    input  logic                  load_en,
    input  logic [NBYTES*8-1:0]   load_val,
    output logic [NBYTES*8-1:0]   value
);

    // One independent byte register per lane; a full-word load wins.
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        logic [7:0] byte_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                byte_q <= '0;
            end else if (load_en) begin
                byte_q <= load_val[b*8 +: 8];
            end else if (wr_en && (lane == 2'(b))) begin
                byte_q <= wdata;
            end
        end

        assign value[b*8 +: 8] = byte_q;
    end

endmodule

// File: rtl/diag_host_port.sv
module diag_host_port
    import diag_window_pkg::*;
#(
    parameter int HOST_AW = 4,
    parameter int NB_A    = 4,
    parameter int NB_D    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [HOST_AW-1:0]   host_addr,
    input  logic                 host_wr,
    input  logic                 host_rd,
    input  logic [7:0]           host_wdata,
    output logic [7:0]           host_rdata,
    output logic                 host_ready,
    input  logic [NB_A*8-1:0]    raddr_val,
    input  logic [NB_A*8-1:0]    waddr_val,
    input  logic [NB_D*8-1:0]    data_val,
    input  logic                 busy,
    output logic                 raddr_we,
    output logic                 waddr_we,
    output logic                 data_we,
    output logic [1:0]           lane,
    output logic                 trig_rd,
    output logic                 trig_wr,
    output logic                 overrun
);

    localparam int WIDE = 8 * REG_LANES;

    logic       hit;
    reg_sel_t   sel;
    logic       stat_we;
    logic       ovr_q;
    logic [7:0] rd_mux;
    logic [7:0] rdata_q;
    logic       ready_q;

    function automatic logic [7:0] pick_lane(input logic [WIDE-1:0] v, input logic [1:0] l);
        return v[l*8 +: 8];
    endfunction

    assign hit  = ((host_addr >> 4) == '0);
    assign sel  = reg_sel_t'(host_addr[3:2]);
    assign lane = host_addr[1:0];

    // Write decode
    always_comb begin
        raddr_we = 1'b0;
        waddr_we = 1'b0;
        data_we  = 1'b0;
        stat_we  = 1'b0;
        if (host_wr && hit) begin
            unique case (sel)
                RSEL_RADDR: raddr_we = 1'b1;
                RSEL_WADDR: waddr_we = 1'b1;
                RSEL_DATA:  data_we  = 1'b1;
                RSEL_STAT:  stat_we  = 1'b1;
            endcase
        end
    end

    assign trig_rd = raddr_we && (lane == 2'd0);
    assign trig_wr = waddr_we && (lane == 2'd0);

    // Sticky overrun: set by a trigger while busy, cleared by write-one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
        end else if ((trig_rd || trig_wr) && busy) begin
            ovr_q <= 1'b1;
        end else if (stat_we && (lane == 2'd0) && host_wdata[STAT_OVR]) begin
            ovr_q <= 1'b0;
        end
    end

    assign overrun = ovr_q;

    // Readback mux
    always_comb begin
        rd_mux = 8'h00;
        if (hit) begin
            unique case (sel)
                RSEL_RADDR: rd_mux = pick_lane(WIDE'(raddr_val), lane);
                RSEL_WADDR: rd_mux = pick_lane(WIDE'(waddr_val), lane);
                RSEL_DATA:  rd_mux = pick_lane(WIDE'(data_val), lane);
                RSEL_STAT: begin
                    if (lane == 2'd0) begin
                        rd_mux[STAT_BUSY] = busy;
                        rd_mux[STAT_OVR]  = ovr_q;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= 8'h00;
            ready_q <= 1'b0;
        end else begin
            ready_q <= host_wr || host_rd;
            if (host_rd) begin
                rdata_q <= rd_mux;
            end
        end
    end

    assign host_rdata = rdata_q;
    assign host_ready = ready_q;

endmodule

// File: rtl/diag_cycle_fsm.sv
module diag_cycle_fsm
    import diag_window_pkg::*;
#(
    parameter int MEM_AW   = 32,
    parameter int MEM_DW   = 32,
    parameter int WORD_LSB = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       trig_rd,
    input  logic                       trig_wr,
    input  logic [MEM_AW-WORD_LSB-1:0] trig_addr,
    input  logic [MEM_DW-1:0]          trig_wdata,
    input  logic                       mem_gnt,
    input  logic                       mem_rvalid,
    output logic                       mem_req,
    output logic                       mem_we,
    output logic [MEM_AW-1:0]          mem_addr,
    output logic [MEM_DW-1:0]          mem_wdata,
    output logic                       busy,
    output logic                       rd_done
);

    cyc_state_t state_q, state_d;
    logic [MEM_AW-WORD_LSB-1:0] addr_q;
    logic [MEM_DW-1:0]          wdata_q;
    logic                       launch;

    assign launch = (state_q == ST_IDLE) && (trig_rd || trig_wr);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (trig_rd)      state_d = ST_RD_REQ;
                else if (trig_wr) state_d = ST_WR_REQ;
            end
            ST_RD_REQ:  if (mem_gnt)    state_d = ST_RD_WAIT;
            ST_RD_WAIT: if (mem_rvalid) state_d = ST_IDLE;
            ST_WR_REQ:  if (mem_gnt)    state_d = ST_IDLE;
        endcase
    end

    // Cycle address and write word are frozen at launch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (launch) begin
            addr_q  <= trig_addr;
            wdata_q <= trig_wdata;
        end
    end

    // Outputs
    always_comb begin
        mem_req = 1'b0;
        mem_we  = 1'b0;
        busy    = 1'b1;
        rd_done = 1'b0;
        unique case (state_q)
            ST_IDLE:    busy = 1'b0;
            ST_RD_REQ:  mem_req = 1'b1;
            ST_RD_WAIT: rd_done = mem_rvalid;
            ST_WR_REQ: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
        endcase
    end

    assign mem_addr  = {addr_q, {WORD_LSB{1'b0}}};
    assign mem_wdata = wdata_q;

endmodule

// File: rtl/diag_window.sv
module diag_window
    import diag_window_pkg::*;
#(
    parameter int HOST_AW = 4,
    parameter int MEM_AW  = 32,
    parameter int MEM_DW  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [HOST_AW-1:0]  host_addr,
    input  logic                host_wr,
    input  logic                host_rd,
    input  logic [7:0]          host_wdata,
    output logic [7:0]          host_rdata,
    output logic                host_ready,
    output logic                mem_req,
    output logic                mem_we,
    output logic [MEM_AW-1:0]   mem_addr,
    output logic [MEM_DW-1:0]   mem_wdata,
    input  logic                mem_gnt,
    input  logic                mem_rvalid,
    input  logic [MEM_DW-1:0]   mem_rdata
);

    localparam int NB_A     = MEM_AW / 8;
    localparam int NB_D     = MEM_DW / 8;
    localparam int WORD_LSB = $clog2(NB_D);

    logic [MEM_AW-1:0] raddr_q, waddr_q;
    logic [MEM_DW-1:0] data_q;
    logic              raddr_we, waddr_we, data_we;
    logic [1:0]        lane;
    logic              trig_rd, trig_wr;
    logic              busy_w, ovr_w, rd_done;
    logic [MEM_AW-WORD_LSB-1:0] trig_addr;

    diag_host_port #(
        .HOST_AW (HOST_AW),
        .NB_A    (NB_A),
        .NB_D    (NB_D)
    ) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .host_ready (host_ready),
        .raddr_val  (raddr_q),
        .waddr_val  (waddr_q),
        .data_val   (data_q),
        .busy       (busy_w),
        .raddr_we   (raddr_we),
        .waddr_we   (waddr_we),
        .data_we    (data_we),
        .lane       (lane),
        .trig_rd    (trig_rd),
        .trig_wr    (trig_wr),
        .overrun    (ovr_w)
    );

    diag_byte_reg #(.NBYTES(NB_A)) u_raddr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (raddr_we),
        .lane     (lane),
        .wdata    (host_wdata),
        .load_en  (1'b0),
        .load_val ({MEM_AW{1'b0}}),
        .value    (raddr_q)
    );

    diag_byte_reg #(.NBYTES(NB_A)) u_waddr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (waddr_we),
        .lane     (lane),
        .wdata    (host_wdata),
        .load_en  (1'b0),
        .load_val ({MEM_AW{1'b0}}),
        .value    (waddr_q)
    );

    diag_byte_reg #(.NBYTES(NB_D)) u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (data_we),
        .lane     (lane),
        .wdata    (host_wdata),
        .load_en  (rd_done),
        .load_val (mem_rdata),
        .value    (data_q)
    );

    // Trigger address: staged upper bytes plus the byte arriving now
    always_comb begin
        if (trig_rd) begin
            trig_addr = {raddr_q[MEM_AW-1:8], host_wdata[7:WORD_LSB]};
        end else begin
            trig_addr = {waddr_q[MEM_AW-1:8], host_wdata[7:WORD_LSB]};
        end
    end

    diag_cycle_fsm #(
        .MEM_AW   (MEM_AW),
        .MEM_DW   (MEM_DW),
        .WORD_LSB (WORD_LSB)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_rd    (trig_rd),
        .trig_wr    (trig_wr),
        .trig_addr  (trig_addr),
        .trig_wdata (data_q),
        .mem_gnt    (mem_gnt),
        .mem_rvalid (mem_rvalid),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .busy       (busy_w),
        .rd_done    (rd_done)
    );

endmodule

// File: rtl/diag_window_chk.sv
module diag_window_chk #(
    parameter int HOST_AW = 4,
    parameter int MEM_AW  = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic [HOST_AW-1:0]  host_addr,
    input logic                host_wr,
    input logic                host_rd,
    input logic                host_ready,
    input logic                mem_req,
    input logic                mem_we,
    input logic                mem_gnt,
    input logic                mem_rvalid,
    input logic [MEM_AW-1:0]   mem_addr,
    input logic                busy,
    input logic                overrun
);

    AST_READY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr || host_rd) |=> host_ready); // R11

    AST_STAGE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_req && host_wr && (host_addr[1:0] != 2'd0) && (host_addr < HOST_AW'(8))) |=> !mem_req); // R2

    AST_RD_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && host_wr && (host_addr == HOST_AW'(0))) |=> (mem_req && !mem_we)); // R3

    AST_WR_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && host_wr && (host_addr == HOST_AW'(4))) |=> (mem_req && mem_we)); // R4

    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00)); // R3

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R5

    AST_RD_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_req && mem_rvalid) |=> !busy); // R6

    AST_WR_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_gnt) |=> !busy); // R7

    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && host_wr && ((host_addr == HOST_AW'(0)) || (host_addr == HOST_AW'(4)))) |=> overrun); // R9

endmodule

bind diag_window diag_window_chk #(
    .HOST_AW (HOST_AW),
    .MEM_AW  (MEM_AW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_ready (host_ready),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_gnt    (mem_gnt),
    .mem_rvalid (mem_rvalid),
    .mem_addr   (mem_addr),
    .busy       (busy_w),
    .overrun    (ovr_w)
);

// File: tb/test_diag_window.sv
module test_diag_window;

    localparam int HAW = 4;
    localparam int AW  = 32;
    localparam int DW  = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [HAW-1:0] host_addr = '0;
    logic           host_wr = 1'b0;
    logic           host_rd = 1'b0;
    logic [7:0]     host_wdata = '0;
    logic [7:0]     host_rdata;
    logic           host_ready;
    logic           mem_req, mem_we;
    logic [AW-1:0]  mem_addr;
    logic [DW-1:0]  mem_wdata;
    logic           mem_gnt = 1'b0;
    logic           mem_rvalid = 1'b0;
    logic [DW-1:0]  mem_rdata = '0;

    always #2 clk = ~clk;  // 250 MHz

    diag_window #(.HOST_AW(HAW), .MEM_AW(AW), .MEM_DW(DW)) i_diag_window (
        .clk(clk), .rst_n(rst_n),
        .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_ready(host_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // ---------------- behavioural RAM ----------------
    logic [31:0] ram    [64];
    logic [31:0] shadow [64];
    logic [31:0] last_addr = '0;
    logic        last_we = 1'b0;
    logic [31:0] last_wdata = '0;
    int          n_hs = 0;
    int          gnt_dly = -1;
    int          rv_dly = 0;
    bit          pend_rd = 0;
    bit          slow_rv = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            mem_gnt = 1'b0; mem_rvalid = 1'b0; gnt_dly = -1; pend_rd = 0;
        end else begin
            mem_rvalid = 1'b0;
            if (mem_gnt) begin
                mem_gnt = 1'b0;
                n_hs++;
                gnt_dly = -1;
                if (last_we) ram[last_addr[7:2]] = last_wdata;
                else begin
                    pend_rd = 1;
                    rv_dly = slow_rv ? 6 : 1 + int'($urandom % 3);
                end
            end else if (mem_req) begin
                if (gnt_dly < 0) gnt_dly = int'($urandom % 3);
                if (gnt_dly == 0) begin
                    mem_gnt = 1'b1;
                    last_addr = mem_addr; last_we = mem_we; last_wdata = mem_wdata;
                end else gnt_dly--;
            end
            if (pend_rd) begin
                if (rv_dly == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata = ram[last_addr[7:2]];
                    pend_rd = 0;
                end else rv_dly--;
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hwrite(input logic [3:0] a, input logic [7:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        host_wr = 1'b0;
        chk(32'(host_ready), 1, "R11 ready after write");
    endtask

    task automatic hread(input logic [3:0] a, output logic [7:0] d);
        host_addr = a; host_rd = 1'b1;
        @(posedge clk); @(negedge clk);
        host_rd = 1'b0;
        chk(32'(host_ready), 1, "R11 ready after read");
        d = host_rdata;
    endtask

    task automatic wait_idle(input string tag);
        logic [7:0] s;
        s = 8'h01;
        for (int k = 0; k < 60; k++) begin
            hread(4'd12, s);
            if (!s[0]) break;
        end
        chk(32'(s[0]), 0, tag);
    endtask

    // style 0: bytes 3,2,1 then 0; style 1: bytes 1..3 then a full 0..3 burst
    task automatic set_addr(input logic [3:0] base, input logic [31:0] a, input bit style);
        if (!style) begin
            for (int b = 3; b >= 0; b--) hwrite(base + 4'(b), a[b*8 +: 8]);
        end else begin
            for (int b = 1; b < 4; b++) hwrite(base + 4'(b), a[b*8 +: 8]);
            for (int b = 0; b < 4; b++) hwrite(base + 4'(b), a[b*8 +: 8]);
        end
    endtask

    task automatic write_word(input logic [31:0] a, input logic [31:0] d, input bit style);
        for (int b = 0; b < 4; b++) hwrite(4'd8 + 4'(b), d[b*8 +: 8]);
        set_addr(4'd4, a, style);
        wait_idle("R7 write cycle ends");
        chk(last_addr, {a[31:2], 2'b00}, "R4 aligned write address");
        chk(32'(last_we), 1, "R4 direction is write");
        chk(ram[a[7:2]], d, "R4 memory word written");
        shadow[a[7:2]] = d;
    endtask

    task automatic read_word(input logic [31:0] a, output logic [31:0] d, input bit style);
        logic [7:0] v;
        set_addr(4'd0, a, style);
        wait_idle("R6 read cycle ends");
        chk(last_addr, {a[31:2], 2'b00}, "R3 aligned read address");
        chk(32'(last_we), 0, "R3 direction is read");
        for (int b = 0; b < 4; b++) begin
            hread(4'd8 + 4'(b), v);
            d[b*8 +: 8] = v;
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    // ---------------- main ----------------
    initial begin
        logic [7:0]  v;
        logic [31:0] w;
        int          hs0;
        void'($urandom(32'h1bad5eed));
        for (int i = 0; i < 64; i++) begin ram[i] = '0; shadow[i] = '0; end

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk(32'(mem_req), 0, "R1 mem_req idle");
        for (int o = 0; o < 16; o++) begin
            hread(4'(o), v);
            chk(32'(v), 0, "R1 register zero");
        end

        // R2: staging bytes only
        hs0 = n_hs;
        hwrite(4'd1, 8'hAA); hwrite(4'd2, 8'hBB); hwrite(4'd3, 8'hCC);
        hwrite(4'd5, 8'h11); hwrite(4'd6, 8'h22); hwrite(4'd7, 8'h33);
        hread(4'd1, v); chk(32'(v), 32'hAA, "R2 raddr byte1");
        hread(4'd2, v); chk(32'(v), 32'hBB, "R2 raddr byte2");
        hread(4'd3, v); chk(32'(v), 32'hCC, "R2 raddr byte3");
        hread(4'd0, v); chk(32'(v), 32'h00, "R2 raddr byte0 untouched");
        hread(4'd7, v); chk(32'(v), 32'h33, "R2 waddr byte3");
        chk(32'(n_hs - hs0), 0, "R2 no memory traffic");
        chk(32'(mem_req), 0, "R2 no request");

        // R10: repeated identical staging writes
        for (int k = 0; k < 4; k++) hwrite(4'd6, 8'h22);
        hread(4'd6, v);  chk(32'(v), 32'h22, "R10 byte kept");
        hread(4'd5, v);  chk(32'(v), 32'h11, "R10 neighbour kept");
        hread(4'd12, v); chk(32'(v), 32'h00, "R10 status unchanged");
        chk(32'(n_hs - hs0), 0, "R10 no memory traffic");

        // Directed round trip with unaligned low bits
        write_word(32'h0000_1235, 32'hDEAD_BEEF, 1'b0);
        for (int b = 0; b < 4; b++) hwrite(4'd8 + 4'(b), 8'h5A);  // preload, must be replaced
        read_word(32'h0000_1234, w, 1'b1);
        chk(w, 32'hDEAD_BEEF, "R6 read data loaded");
        read_word(32'h0000_1238, w, 1'b0);
        chk(w, 32'h0, "R6 next word still zero");

        // R8/R9: triggers while busy
        slow_rv = 1;
        hs0 = n_hs;
        for (int b = 3; b >= 1; b--) hwrite(4'(b), 8'h00);
        hwrite(4'd0, 8'h40);
        hread(4'd12, v); chk(32'(v[0]), 1, "R8 busy visible");
        hwrite(4'd0, 8'h80);
        hwrite(4'd4, 8'h80);
        wait_idle("R6 busy clears after slow read");
        slow_rv = 0;
        chk(32'(n_hs - hs0), 1, "R9 late triggers start no cycle");
        chk(last_addr, 32'h0000_0040, "R9 in-flight address kept");
        hread(4'd0, v);  chk(32'(v), 32'h80, "R9 byte still stored");
        hread(4'd12, v); chk(32'(v), 32'h02, "R9 overrun set");
        hwrite(4'd12, 8'h01);
        hread(4'd12, v); chk(32'(v), 32'h02, "R9 overrun sticky");
        hwrite(4'd12, 8'h02);
        hread(4'd12, v); chk(32'(v), 32'h00, "R9 overrun cleared");

        // Constrained random traffic
        for (int it = 0; it < 40; it++) begin
            logic [31:0] a, d;
            logic [5:0]  idx;
            idx = 6'($urandom % 64);
            a = $urandom;
            a[7:2] = idx;
            if (($urandom % 10) < 6) begin
                d = $urandom;
                write_word(a, d, 1'($urandom % 2));
            end else begin
                read_word(a, w, 1'($urandom % 2));
                chk(w, shadow[idx], "R6 random read matches");
            end
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule